// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Decoder

This block sits on the cartridge side of an 8-bit console and turns CPU writes in the upper half of the address map into bank settings. A write commits when the active-low write strobe falls while CPU A15 is high. The register is chosen from A15..A10, and a couple of low address bits refine one slot. Because the select ignores A9..A0 everywhere else, the registers repeat every 1 KB.

The stored settings shape three outputs. The PRG ROM address is a bank number joined with CPU A12..A0. There are three switchable 8 KB windows, and the top window is tied to the last bank. The CHR ROM address is one of eight 8-bit 1 KB bank numbers, chosen by PPU A12..A10, joined with PPU A9..A0. The block also outputs a single-screen nametable page and its enable flag. It holds an 8-bit interrupt reload value and a control byte for an external counter, and it raises a one-cycle acknowledge pulse.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, every bank register, the mirroring page and flag, the interrupt reload value and the control byte are zero.
- R2: A write with A15..A10 = 100000 stores D5..D0 as the bank for CPU window $8000-$9FFF; A9..A0 of the write address are ignored.
- R3: A write with A15..A10 = 101000 stores D5..D0 as the bank for CPU window $A000-$BFFF.
- R4: A write with A15..A10 = 100111 and A2 = 0 stores D4..D0, zero-extended, as the bank for CPU window $C000-$DFFF.
- R5: CPU window $E000-$FFFF always maps to the last bank (all bank bits one).
- R6: The PRG ROM address is {bank, A12..A0}. The CHR ROM address is {bank[PPU A12..A10], PPU A9..A0}. CHR slot n (0..7) takes its low nibble from D3..D0 at $B000 + n*$800 and its high nibble from D7..D4 at the same address + $400.
- R7: A write with A15..A10 = 100111 and A2 = 1 sets the nametable page to A1..A0 and the single-screen flag to D0.
- R8: Writes at $F000 and $F400 (1 KB aliases) load D3..D0 into the low and the high nibble of the interrupt reload value.
- R9: A write at $F800 stores the full data byte as the control byte. A write at $FC00 produces exactly one clock cycle of high acknowledge, one cycle after the commit edge.
- R10: Nothing changes except on a falling strobe with A15 = 1. A strobe held low commits only the data present when it fell. Writes with A15 = 0, and writes to unused slots such as $8400, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobe is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr_n | input | 1 | Active-low CPU write strobe |
| ppu_addr | input | 13 | PPU pattern address A12..A0 |
| prg_addr | output | 19 | Banked PRG ROM address |
| chr_addr | output | 18 | Banked CHR ROM address |
| mirror_page | output | 2 | Selected nametable page |
| mirror_single | output | 1 | Single-screen mirroring flag |
| irq_latch | output | 8 | Interrupt counter reload value |
| irq_ctrl | output | 8 | Interrupt control byte |
| irq_ack | output | 1 | One-cycle acknowledge pulse |

## Verification
A CHR bank write and a PPU fetch through that same 1 KB slot can land in the same cycle. The rewrite goes through the CPU port while the PPU address stays fixed on the slot being rewritten. The bench reads the CHR address once between the strobe fall and the commit edge, where it must still show the old bank, and once after that edge, where it must show the new one. The same kind of window check compares the PRG address before and after commits while the CPU address points into the affected window.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   localparam int SLOT_W = 3;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_PRG_A,
      SEL_PRG_B,
      SEL_PRG_C,
      SEL_MIRROR,
      SEL_CHR_LO,
      SEL_CHR_HI,
      SEL_LATCH_LO,
      SEL_LATCH_HI,
      SEL_CTRL,
      SEL_ACK
   } wsel_e;

   typedef struct packed {
      wsel_e             sel;
      logic [SLOT_W-1:0] slot;
      logic [1:0]        page;
   } wdec_t;
endpackage

// File: rtl/cbm_decode.sv
module cbm_decode
   import cbm_pkg::*;
(
   input  logic [5:0] addr_hi,   // A15..A10
   input  logic [2:0] addr_lo,   // A2..A0
   output wdec_t      dec
);
   localparam logic [3:0] CHR_FIRST = 4'd6;   // A14..A11 of $B000
   localparam logic [3:0] CHR_LAST  = 4'd13;  // A14..A11 of $E800

   logic [3:0] pair_idx;
   logic [3:0] slot_full;

   assign pair_idx  = addr_hi[4:1];
   assign slot_full = pair_idx - CHR_FIRST;

   always_comb begin
      dec      = '{sel: SEL_NONE, slot: '0, page: addr_lo[1:0]};
      if (addr_hi[5]) begin
         case (addr_hi[4:0])
            5'b00000: dec.sel = SEL_PRG_A;
            5'b01000: dec.sel = SEL_PRG_B;
            5'b00111: dec.sel = addr_lo[2] ? SEL_MIRROR : SEL_PRG_C;
            5'b11100: dec.sel = SEL_LATCH_LO;
            5'b11101: dec.sel = SEL_LATCH_HI;
            5'b11110: dec.sel = SEL_CTRL;
            5'b11111: dec.sel = SEL_ACK;
            default: begin
               if (pair_idx >= CHR_FIRST && pair_idx <= CHR_LAST) begin
                  dec.sel  = addr_hi[0] ? SEL_CHR_HI : SEL_CHR_LO;
                  dec.slot = slot_full[SLOT_W-1:0];
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cbm_regfile.sv
module cbm_regfile
   import cbm_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int PRG_BANK_W = 6,
   parameter int PRG_C_W    = 5,
   parameter int CHR_BANK_W = 8,
   parameter int CHR_SLOTS  = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_fire,
   input  wdec_t                                 dec,
   input  logic [DATA_W-1:0]                     data,
   output logic [PRG_BANK_W-1:0]                 prg_a,
   output logic [PRG_BANK_W-1:0]                 prg_b,
   output logic [PRG_C_W-1:0]                    prg_c,
   output logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_bank,
   output logic [1:0]                            page,
   output logic                                  single,
   output logic [DATA_W-1:0]                     latch,
   output logic [DATA_W-1:0]                     ctrl,
   output logic                                  ack
);
   localparam int HALF = CHR_BANK_W / 2;
   localparam int LHALF = DATA_W / 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prg_a  <= '0;
         prg_b  <= '0;
         prg_c  <= '0;
         page   <= '0;
         single <= 1'b0;
         latch  <= '0;
         ctrl   <= '0;
         ack    <= 1'b0;
      end else begin
         ack <= wr_fire && (dec.sel == SEL_ACK);
         if (wr_fire) begin
            case (dec.sel)
               SEL_PRG_A:    prg_a <= data[PRG_BANK_W-1:0];
               SEL_PRG_B:    prg_b <= data[PRG_BANK_W-1:0];
               SEL_PRG_C:    prg_c <= data[PRG_C_W-1:0];
               SEL_MIRROR: begin
                  page   <= dec.page;
                  single <= data[0];
               end
               SEL_LATCH_LO: latch[LHALF-1:0]      <= data[LHALF-1:0];
               SEL_LATCH_HI: latch[DATA_W-1:LHALF] <= data[LHALF-1:0];
               SEL_CTRL:     ctrl <= data;
               default: ;
            endcase
         end
      end
   end

   for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_chr
      logic [CHR_BANK_W-1:0] bank_q;
      logic                  hit;
      assign hit = wr_fire && (dec.slot == SLOT_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q <= '0;
         end else if (hit && dec.sel == SEL_CHR_LO) begin
            bank_q[HALF-1:0] <= data[HALF-1:0];
         end else if (hit && dec.sel == SEL_CHR_HI) begin
            bank_q[CHR_BANK_W-1:HALF] <= data[DATA_W-1:HALF];
         end
      end
      assign chr_bank[s] = bank_q;
   end
endmodule

// File: rtl/cbm_bank_mux.sv
module cbm_bank_mux #(
   parameter int PRG_BANK_W = 6,
   parameter int PRG_C_W    = 5,
   parameter int CHR_BANK_W = 8,
   parameter int CHR_SLOTS  = 8,
   parameter int PRG_WIN_W  = 13,
   parameter int CHR_WIN_W  = 10,
   localparam int PRG_AW    = PRG_BANK_W + PRG_WIN_W,
   localparam int CHR_AW    = CHR_BANK_W + CHR_WIN_W,
   localparam int SLOT_W    = $clog2(CHR_SLOTS)
) (
   input  logic [PRG_WIN_W+1:0]                  cpu_addr,
   input  logic [CHR_WIN_W+SLOT_W-1:0]           ppu_addr,
   input  logic [PRG_BANK_W-1:0]                 prg_a,
   input  logic [PRG_BANK_W-1:0]                 prg_b,
   input  logic [PRG_C_W-1:0]                    prg_c,
   input  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_bank,
   output logic [PRG_AW-1:0]                     prg_addr,
   output logic [CHR_AW-1:0]                     chr_addr
);
   logic [PRG_BANK_W-1:0] bank_sel;
   logic [SLOT_W-1:0]     slot;

   always_comb begin
      case (cpu_addr[PRG_WIN_W+1:PRG_WIN_W])
         2'b00:   bank_sel = prg_a;
         2'b01:   bank_sel = prg_b;
         2'b10:   bank_sel = PRG_BANK_W'(prg_c);
         default: bank_sel = '1;
      endcase
   end

   assign prg_addr = {bank_sel, cpu_addr[PRG_WIN_W-1:0]};
   assign slot     = ppu_addr[CHR_WIN_W+SLOT_W-1:CHR_WIN_W];
   assign chr_addr = {chr_bank[slot], ppu_addr[CHR_WIN_W-1:0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import cbm_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int PRG_BANK_W = 6,
   parameter int PRG_C_W    = 5,
   parameter int CHR_BANK_W = 8,
   parameter int CHR_SLOTS  = 8,
   localparam int PRG_AW    = PRG_BANK_W + 13,
   localparam int CHR_AW    = CHR_BANK_W + 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_wr_n,
   input  logic [12:0]       ppu_addr,
   output logic [PRG_AW-1:0] prg_addr,
   output logic [CHR_AW-1:0] chr_addr,
   output logic [1:0]        mirror_page,
   output logic              mirror_single,
   output logic [DATA_W-1:0] irq_latch,
   output logic [DATA_W-1:0] irq_ctrl,
   output logic              irq_ack
);
   if (DATA_W != 8) begin : g_bad_data
      $error("cart_bank_mapper: DATA_W must be 8");
   end
   if (CHR_SLOTS != (1 << SLOT_W)) begin : g_bad_slots
      $error("cart_bank_mapper: CHR_SLOTS must match the package slot width");
   end
   if (CHR_BANK_W != DATA_W) begin : g_bad_chr
      $error("cart_bank_mapper: CHR bank is built from two data nibbles");
   end
   if (PRG_C_W > PRG_BANK_W || PRG_BANK_W > DATA_W - 2) begin : g_bad_prg
      $error("cart_bank_mapper: PRG bank widths out of range");
   end

   logic  wr_prev;
   logic  wr_fire;
   wdec_t dec;
   logic [PRG_BANK_W-1:0]                prg_a, prg_b;
   logic [PRG_C_W-1:0]                   prg_c;
   logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_bank;

   // Strobe level from the previous edge; reset low so a strobe already
   // asserted when reset lifts does not count as a fall.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_prev <= 1'b0;
      else        wr_prev <= cpu_wr_n;
   end
   assign wr_fire = wr_prev && !cpu_wr_n;

   cbm_decode u_dec (
      .addr_hi (cpu_addr[15:10]),
      .addr_lo (cpu_addr[2:0]),
      .dec     (dec)
   );

   cbm_regfile #(
      .DATA_W(DATA_W), .PRG_BANK_W(PRG_BANK_W), .PRG_C_W(PRG_C_W),
      .CHR_BANK_W(CHR_BANK_W), .CHR_SLOTS(CHR_SLOTS)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_fire  (wr_fire),
      .dec      (dec),
      .data     (cpu_data),
      .prg_a    (prg_a),
      .prg_b    (prg_b),
      .prg_c    (prg_c),
      .chr_bank (chr_bank),
      .page     (mirror_page),
      .single   (mirror_single),
      .latch    (irq_latch),
      .ctrl     (irq_ctrl),
      .ack      (irq_ack)
   );

   cbm_bank_mux #(
      .PRG_BANK_W(PRG_BANK_W), .PRG_C_W(PRG_C_W),
      .CHR_BANK_W(CHR_BANK_W), .CHR_SLOTS(CHR_SLOTS)
   ) u_mux (
      .cpu_addr (cpu_addr[14:0]),
      .ppu_addr (ppu_addr),
      .prg_a    (prg_a),
      .prg_b    (prg_b),
      .prg_c    (prg_c),
      .chr_bank (chr_bank),
      .prg_addr (prg_addr),
      .chr_addr (chr_addr)
   );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
   parameter int PRG_AW = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       cpu_addr,
   input logic              cpu_wr_n,
   input logic [PRG_AW-1:0] prg_addr,
   input logic [1:0]        mirror_page,
   input logic              mirror_single,
   input logic [7:0]        irq_latch,
   input logic [7:0]        irq_ctrl,
   input logic              irq_ack
);
   // R9: acknowledge never lasts two cycles
   p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);

   // R9: acknowledge follows a strobe-low cycle addressing the $FC00 slot
   p_ack_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> ($past(cpu_wr_n) == 1'b0 && $past(cpu_addr[15:10]) == 6'b111111));

   // R5: top window always reaches the last bank
   p_last_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr[15:13] == 3'b111 |-> prg_addr[PRG_AW-1:13] == '1);

   // R10: no commit while the strobe was already high at the previous edge
   p_hold_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cpu_wr_n) |-> ($stable(irq_latch) && $stable(irq_ctrl) &&
                           $stable(mirror_page) && $stable(mirror_single)));

   // R10: writes with A15 low leave the stored values alone
   p_low_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cpu_addr[15]) |-> ($stable(irq_latch) && $stable(irq_ctrl) &&
                                $stable(mirror_page)));

   // R6: PRG offset bits pass straight through
   p_prg_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prg_addr[12:0] == cpu_addr[12:0]);
endmodule

bind cart_bank_mapper cbm_checker #(.PRG_AW(PRG_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr_n(cpu_wr_n),
   .prg_addr(prg_addr), .mirror_page(mirror_page), .mirror_single(mirror_single),
   .irq_latch(irq_latch), .irq_ctrl(irq_ctrl), .irq_ack(irq_ack)
);

// File: tb/cart_bank_mapper_tb_top.sv
module cart_bank_mapper_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr;
   logic [7:0]  cpu_data = 8'h00;
   logic        cpu_wr_n = 1'b1;
   logic [12:0] ppu_addr = '0;
   logic [18:0] prg_addr;
   logic [17:0] chr_addr;
   logic [1:0]  mirror_page;
   logic        mirror_single;
   logic [7:0]  irq_latch, irq_ctrl;
   logic        irq_ack;

   logic        drv_active = 1'b0;
   logic [15:0] drv_addr = '0;
   logic [15:0] mon_addr = '0;
   assign cpu_addr = drv_active ? drv_addr : mon_addr;

   int checks = 0;
   int errors = 0;
   int ack_cnt = 0;
   int ack_run = 0;
   int ack_long = 0;

   typedef struct {
      int          kind;   // 0 prg, 1 chr, 2 mirror, 3 latch, 4 ctrl, 5 ack
      logic [15:0] probe;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #10 clk = ~clk;

   cart_bank_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr_n(cpu_wr_n), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
      .chr_addr(chr_addr), .mirror_page(mirror_page), .mirror_single(mirror_single),
      .irq_latch(irq_latch), .irq_ctrl(irq_ctrl), .irq_ack(irq_ack)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic expect_item(int kind, logic [15:0] probe, logic [31:0] exp, string tag);
      item_t it;
      it.kind = kind; it.probe = probe; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic cpu_write(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      drv_active = 1'b1; drv_addr = a; cpu_data = d; cpu_wr_n = 1'b0;
      @(negedge clk);
      cpu_wr_n = 1'b1;
      @(negedge clk);
      drv_active = 1'b0;
   endtask

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         wait (sb_q.size() > 0);
         @(negedge clk);
         case (sb_q[0].kind)
            0: mon_addr = sb_q[0].probe;
            1: ppu_addr = sb_q[0].probe[12:0];
            default: ;
         endcase
         #2;
         case (sb_q[0].kind)
            0: chk(sb_q[0].tag, 32'(prg_addr), sb_q[0].exp);
            1: chk(sb_q[0].tag, 32'(chr_addr), sb_q[0].exp);
            2: chk(sb_q[0].tag, {29'd0, mirror_single, mirror_page}, sb_q[0].exp);
            3: chk(sb_q[0].tag, 32'(irq_latch), sb_q[0].exp);
            4: chk(sb_q[0].tag, 32'(irq_ctrl), sb_q[0].exp);
            default: chk(sb_q[0].tag, 32'(ack_cnt * 16 + ack_long), sb_q[0].exp);
         endcase
         void'(sb_q.pop_front());
      end
   end

   // acknowledge pulse counter, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && irq_ack) begin
         ack_run++;
         if (ack_run == 1) ack_cnt++;
         else ack_long++;
      end else begin
         ack_run = 0;
      end
   end

   function automatic logic [7:0] chr_bank_of(int i);
      logic [3:0] lo = 4'(i + 3);
      logic [3:0] hi = 4'(i) ^ 4'hA;
      return {hi, lo};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      expect_item(0, 16'hA123, {6'h00, 13'h0123}, "R1 prg window B");
      expect_item(1, 16'h1C05, {8'h00, 10'h005}, "R1 chr slot 7");
      expect_item(2, 16'h0, 32'h0, "R1 mirroring");
      expect_item(3, 16'h0, 32'h0, "R1 irq latch");
      expect_item(4, 16'h0, 32'h0, "R1 irq ctrl");

      // R2 / R3 / R4 / R5 PRG windows
      cpu_write(16'h8000, 8'hE5);
      expect_item(0, 16'h8ABC, {6'h25, 13'h0ABC}, "R2 window $8000");
      cpu_write(16'hA3FF, 8'h3A);
      expect_item(0, 16'hB001, {6'h3A, 13'h1001}, "R3 window $A000 alias");
      cpu_write(16'h9C00, 8'hFF);
      expect_item(0, 16'hC010, {6'h1F, 13'h0010}, "R4 window $C000 five bits");
      expect_item(0, 16'hE000, {6'h3F, 13'h0000}, "R5 fixed last bank");
      expect_item(0, 16'hFFFF, {6'h3F, 13'h1FFF}, "R5 fixed last bank top");

      // R6 CHR slots: low nibble first address, high nibble +$400
      for (int i = 0; i < 8; i++) begin
         cpu_write(16'(16'hB000 + i * 16'h0800), {4'hF, chr_bank_of(i)[3:0]});
         cpu_write(16'(16'hB400 + i * 16'h0800), {chr_bank_of(i)[7:4], 4'h5});
      end
      for (int i = 0; i < 8; i++) begin
         expect_item(1, 16'(i * 16'h0400 + 16'h0155), {chr_bank_of(i), 10'h155}, "R6 chr slot");
      end

      // R6 PPU fetch through slot 2 while the CPU rewrites it
      expect_item(1, 16'h0A2A, {8'h85, 10'h22A}, "R6 slot 2 before rewrite");
      @(negedge clk);
      drv_active = 1'b1; drv_addr = 16'hC000; cpu_data = 8'hF1; cpu_wr_n = 1'b0;
      #2 chk("R6 old bank before commit edge", 32'(chr_addr), {14'd0, 8'h85, 10'h22A});
      @(posedge clk);
      #2 chk("R6 new bank after commit edge", 32'(chr_addr), {14'd0, 8'h81, 10'h22A});
      @(negedge clk);
      cpu_wr_n = 1'b1;
      @(negedge clk);
      drv_active = 1'b0;

      // R7 mirroring
      cpu_write(16'h9C06, 8'h01);
      expect_item(2, 16'h0, 32'h6, "R7 page 2 single");
      cpu_write(16'h9C05, 8'hFE);
      expect_item(2, 16'h0, 32'h1, "R7 page 1 flag clear");

      // R8 interrupt reload value
      cpu_write(16'hF000, 8'h3C);
      cpu_write(16'hF7FF, 8'h97);
      expect_item(3, 16'h0, 32'h7C, "R8 latch nibbles");

      // R9 control and acknowledge
      cpu_write(16'hF800, 8'h5A);
      expect_item(4, 16'h0, 32'h5A, "R9 ctrl byte");
      cpu_write(16'hFC00, 8'h00);
      expect_item(5, 16'h0, 32'h10, "R9 one ack pulse, one cycle");

      // R10 strobe held low: only the value at the fall is taken
      @(negedge clk);
      drv_active = 1'b1; drv_addr = 16'h8000; cpu_data = 8'h07; cpu_wr_n = 1'b0;
      @(negedge clk); cpu_data = 8'h09;
      @(negedge clk); cpu_data = 8'h0B;
      @(negedge clk); cpu_wr_n = 1'b1;
      @(negedge clk); drv_active = 1'b0;
      expect_item(0, 16'h8000, {6'h07, 13'h0}, "R10 held strobe");

      cpu_write(16'h2000, 8'h11);
      expect_item(0, 16'hA000, {6'h3A, 13'h0}, "R10 A15 low ignored");
      cpu_write(16'h8400, 8'h01);
      expect_item(0, 16'h8000, {6'h07, 13'h0}, "R10 unused slot ignored");
      cpu_write(16'h7800, 8'hFF);
      expect_item(4, 16'h0, 32'h5A, "R10 A15 low ctrl untouched");
      expect_item(5, 16'h0, 32'h10, "R10 no extra ack");

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule